// File: doc/BRIEF.md
# Load-PC Stride Prefetch Engine

This block watches the stream of load instructions retired by a core. Each load brings its program counter and effective address. A small direct-mapped table, indexed by the low PC bits, remembers per load the last address it touched, the distance between its two most recent addresses, and a two-bit confidence counter. Once a load has repeated the same non-zero distance often enough, the block computes a group of block-aligned prefetch addresses. The group lies a configurable number of strides ahead of the current access, so requests reach memory before the core asks for the data.

Each trigger produces one group of addresses. The group waits in a small FIFO and leaves the block one address per transfer over a ready/valid handshake. When the FIFO has no room for a whole group, the new group is dropped and training continues. The distance ahead (LOOKAHEAD), the group size (DEGREE), the table size, the FIFO depth and the cache-block size are all parameters.

Top module: `ld_stride_prefetcher`

## Requirements
- R1: After an active-low reset, `pf_valid` is 0 and every table entry is invalid, so a load stream trained before the reset must be learned again from the start.
- R2: The table index is `ld_pc[IDX_W-1:0]` and the tag is `ld_pc[PC_W-1:IDX_W]`. When a load misses (the slot is invalid or holds another tag), the slot takes the new tag and the current address, with stride 0 and confidence 0. With a constant non-zero stride, the earliest trigger is the fourth load of the same PC.
- R3: On a hit, the observed stride is the current address minus the stored last address. The two-bit saturating confidence rises by one when the observed stride equals the stored stride and falls by one otherwise. The slot always stores the current address and the observed stride.
- R4: A trigger needs a hit, a matching stride and an updated confidence of at least 2. Because the counter steps by one, a counter at 3 survives a single break: after one mismatch, one further match triggers again.
- R5: A trigger produces DEGREE addresses, in the order k = 0 .. DEGREE-1. Address k is the current address plus (LOOKAHEAD + k) times the stride, modulo 2^ADDR_W, with the low log2(BLK_BYTES) bits cleared.
- R6: An observed stride of zero never triggers, whatever the confidence.
- R7: Negative strides (two's complement) train and trigger like positive ones and produce addresses below the current address.
- R8: Queued addresses leave in FIFO order. `pf_valid` is 1 while the queue holds an entry. An entry is removed when `pf_valid` and `pf_ready` are both 1. While `pf_ready` is 0, `pf_valid` and `pf_addr` hold their values.
- R9: A trigger is accepted only when the free slots, counted before any removal in the same cycle, are at least DEGREE. Otherwise the whole group is dropped, while the table still updates.
- R10: A trigger that reaches an empty queue raises `pf_valid` in the cycle after the edge that samples the load, with the k = 0 address on `pf_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_ready | input | 1 | Downstream accepts a prefetch request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |

## Verification
Two functions can fall in the same cycle: a trigger that adds a group to the queue, and a handshake that removes the head entry. The bench provokes this by loading the queue with one group while `pf_ready` is 0. It then presents a triggering load in the same cycle that it raises `pf_ready`. The occupancy goes from two to three, so the next trigger must be refused (R9). The bench judges the result by draining the queue and comparing every address, in order, against values computed from the requirements. The old head must leave first, then the new group, and the queue must then be empty.

// File: rtl/pf_pkg.sv
// Package: shared confidence type and its saturating update helpers.
// Assumes a two-bit counter; the firing threshold is a fixed constant.
package pf_pkg;
    typedef logic [1:0] conf_t;
    localparam conf_t CONF_FIRE = 2'd2;

    // Saturating increment of the confidence counter.
    function automatic conf_t conf_up(input conf_t c);
        return (c == 2'd3) ? c : c + 2'd1;
    endfunction

    // Saturating decrement of the confidence counter.
    function automatic conf_t conf_down(input conf_t c);
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/stride_table.sv
// Direct-mapped, PC-indexed stride table. Looks up the slot of the
// incoming load, decides whether it triggers, and updates the slot at the
// clock edge. Assumes ENTRIES is a power of two and less than 2**PC_W.
module stride_table
    import pf_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_stride
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic              ent_v      [ENTRIES];
    logic [TAG_W-1:0]  ent_tag    [ENTRIES];
    logic [ADDR_W-1:0] ent_last   [ENTRIES];
    logic [ADDR_W-1:0] ent_stride [ENTRIES];
    conf_t             ent_conf   [ENTRIES];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    logic              same;
    logic [ADDR_W-1:0] obs_stride;
    conf_t             conf_nx;

    // Look up the slot, compute the observed stride and decide on a trigger.
    always_comb begin
        idx        = ld_pc[IDX_W-1:0];
        tag        = ld_pc[PC_W-1:IDX_W];
        hit        = ent_v[idx] && (ent_tag[idx] == tag);
        obs_stride = ld_addr - ent_last[idx];
        same       = (obs_stride == ent_stride[idx]);
        conf_nx    = same ? conf_up(ent_conf[idx]) : conf_down(ent_conf[idx]);
        fire       = ld_valid && hit && same && (conf_nx >= CONF_FIRE)
                     && (obs_stride != '0);
        fire_stride = obs_stride;
    end

    // Clear the table on reset, otherwise allocate or train the indexed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_v[i]      <= 1'b0;
                ent_tag[i]    <= '0;
                ent_last[i]   <= '0;
                ent_stride[i] <= '0;
                ent_conf[i]   <= '0;
            end
        end else if (ld_valid) begin
            ent_v[idx]    <= 1'b1;
            ent_tag[idx]  <= tag;
            ent_last[idx] <= ld_addr;
            if (hit) begin
                ent_stride[idx] <= obs_stride;
                ent_conf[idx]   <= conf_nx;
            end else begin
                ent_stride[idx] <= '0;
                ent_conf[idx]   <= '0;
            end
        end
    end
endmodule

// File: rtl/pf_target_gen.sv
// Target generator: forms DEGREE block-aligned addresses at
// base + (LOOKAHEAD + k) * stride. Pure combinational logic. Assumes
// BLK_BYTES is a power of two of at least 2.
module pf_target_gen #(
    parameter int ADDR_W    = 32,
    parameter int LOOKAHEAD = 2,
    parameter int DEGREE    = 2,
    parameter int BLK_BYTES = 64
) (
    input  logic [ADDR_W-1:0]             base,
    input  logic [ADDR_W-1:0]             stride,
    output logic [DEGREE-1:0][ADDR_W-1:0] tgt
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    for (genvar k = 0; k < DEGREE; k++) begin : g_tgt
        logic [ADDR_W-1:0] raw;
        // One target: scaled stride added to the base, then block-aligned.
        always_comb begin
            raw    = base + stride * ADDR_W'(LOOKAHEAD + k);
            tgt[k] = {raw[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end
endmodule

// File: rtl/pf_queue.sv
// Group FIFO: takes GRP entries at once when enough slots are free
// (counted before this cycle's pop), and gives out one entry per pop.
// Assumes DEPTH is a power of two and GRP <= DEPTH.
module pf_queue #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    parameter int GRP    = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [GRP-1:0][ADDR_W-1:0] push_data,
    input  logic                       pop,
    output logic [ADDR_W-1:0]          head,
    output logic                       nonempty,
    output logic [CNT_W-1:0]           count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              take;
    logic              drop_one;

    // Accept a group only when all of it fits; pop only a present entry.
    always_comb begin
        take     = push && ((int'(DEPTH) - int'(count)) >= GRP);
        drop_one = pop && (count != '0);
        nonempty = (count != '0);
        head     = slot[rptr];
    end

    // Move the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (take)     wptr <= PTR_W'(int'(wptr) + GRP);
            if (drop_one) rptr <= PTR_W'(int'(rptr) + 1);
            count <= CNT_W'(int'(count) + (take ? GRP : 0) - (drop_one ? 1 : 0));
        end
    end

    // Write an accepted group into consecutive slots.
    always_ff @(posedge clk) begin
        if (take) begin
            for (int k = 0; k < GRP; k++) begin
                slot[PTR_W'(int'(wptr) + k)] <= push_data[k];
            end
        end
    end
endmodule

// File: rtl/ld_stride_prefetcher.sv
// Top: PC-indexed stride prefetcher. It trains a stride table on loads,
// turns a confirmed trigger into a group of targets and sends them out
// through a group FIFO with a ready/valid handshake.
// Assumes ENTRIES, QDEPTH, BLK_BYTES are powers of two, DEGREE <= QDEPTH.
module ld_stride_prefetcher #(
    parameter int PC_W      = 16,
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 16,
    parameter int LOOKAHEAD = 2,
    parameter int DEGREE    = 2,
    parameter int QDEPTH    = 4,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic                          grp_push;
    logic [ADDR_W-1:0]             grp_stride;
    logic [DEGREE-1:0][ADDR_W-1:0] grp_tgt;
    logic [CNT_W-1:0]              q_count;
    logic                          q_pop;

    stride_table #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .fire(grp_push), .fire_stride(grp_stride)
    );

    pf_target_gen #(
        .ADDR_W(ADDR_W), .LOOKAHEAD(LOOKAHEAD), .DEGREE(DEGREE),
        .BLK_BYTES(BLK_BYTES)
    ) gen_i (
        .base(ld_addr), .stride(grp_stride), .tgt(grp_tgt)
    );

    // Handshake: an entry leaves when offered and accepted.
    assign q_pop = pf_valid && pf_ready;

    pf_queue #(
        .ADDR_W(ADDR_W), .DEPTH(QDEPTH), .GRP(DEGREE)
    ) queue_i (
        .clk(clk), .rst_n(rst_n), .push(grp_push), .push_data(grp_tgt),
        .pop(q_pop), .head(pf_addr), .nonempty(pf_valid), .count(q_count)
    );
endmodule

// File: rtl/ld_stride_prefetcher_chk.sv
// Checker for the prefetcher top, attached through bind. It observes the
// ports and the group-push and occupancy signals between the submodules.
module ld_stride_prefetcher_chk #(
    parameter int ADDR_W    = 32,
    parameter int QDEPTH    = 4,
    parameter int BLK_BYTES = 64,
    localparam int CNT_W    = $clog2(QDEPTH + 1),
    localparam int OFF_W    = $clog2(BLK_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              grp_push,
    input logic [ADDR_W-1:0] grp_stride,
    input logic [CNT_W-1:0]  q_count
);
    // R1: the cycle after reset is sampled, nothing is offered.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    // R5: every offered address is block aligned.
    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFF_W-1:0] == '0));

    // R6: a group is never pushed for a zero stride.
    assert_no_zero_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_push |-> (grp_stride != '0));

    // R8: a stalled request holds its valid and its address.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    // R9: the occupancy never exceeds the depth.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

    // R10: a trigger into an empty queue is offered on the next cycle.
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grp_push && (q_count == '0) |=> pf_valid);
endmodule

bind ld_stride_prefetcher ld_stride_prefetcher_chk #(
    .ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .BLK_BYTES(BLK_BYTES)
) chk_i (.*);

// File: tb/ld_stride_prefetcher_tb_top.sv
`timescale 1ns/1ps
// Bench: a vector table of loads walked by one loop, each trigger drained
// and compared, then directed tests for simultaneous push/pop, group drop,
// stall hold and reset.
module ld_stride_prefetcher_tb_top;
    localparam int PC_W = 16, ADDR_W = 32, LA = 2, DEG = 2, BLK = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [PC_W-1:0]   ld_pc = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              pf_ready = 1'b0;
    logic              pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ld_stride_prefetcher #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(16), .LOOKAHEAD(LA),
        .DEGREE(DEG), .QDEPTH(4), .BLK_BYTES(BLK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_ready(pf_ready), .pf_valid(pf_valid),
        .pf_addr(pf_addr)
    );

    typedef struct packed {
        logic [15:0] pc;
        logic [31:0] addr;
        logic        trig;
        logic [31:0] stride;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        // positive stride 0x100, trigger on fourth and fifth load (R2 R3 R4)
        '{16'h0040, 32'h0000_1000, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1100, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1200, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1300, 1'b1, 32'h100},
        '{16'h0040, 32'h0000_1400, 1'b1, 32'h100},
        // negative stride (R7)
        '{16'h0051, 32'h0000_8000, 1'b0, 32'h0},
        '{16'h0051, 32'h0000_7F80, 1'b0, 32'h0},
        '{16'h0051, 32'h0000_7F00, 1'b0, 32'h0},
        '{16'h0051, 32'h0000_7E80, 1'b1, 32'hFFFF_FF80},
        // unaligned addresses, targets rounded down (R5)
        '{16'h0062, 32'h0000_2004, 1'b0, 32'h0},
        '{16'h0062, 32'h0000_2048, 1'b0, 32'h0},
        '{16'h0062, 32'h0000_208C, 1'b0, 32'h0},
        '{16'h0062, 32'h0000_20D0, 1'b1, 32'h44},
        // zero stride never triggers (R6)
        '{16'h0073, 32'h0000_3000, 1'b0, 32'h0},
        '{16'h0073, 32'h0000_3000, 1'b0, 32'h0},
        '{16'h0073, 32'h0000_3000, 1'b0, 32'h0},
        '{16'h0073, 32'h0000_3000, 1'b0, 32'h0},
        '{16'h0073, 32'h0000_3000, 1'b0, 32'h0},
        // alias on index 0 evicts PC 0x0040, which must retrain (R2)
        '{16'h0140, 32'h0000_5000, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1500, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1600, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1700, 1'b0, 32'h0},
        '{16'h0040, 32'h0000_1800, 1'b1, 32'h100},
        // confidence 3 survives one break (R4)
        '{16'h0051, 32'h0000_7E00, 1'b1, 32'hFFFF_FF80},
        '{16'h0051, 32'h0000_9000, 1'b0, 32'h0},
        '{16'h0051, 32'h0000_9040, 1'b0, 32'h0},
        '{16'h0051, 32'h0000_9080, 1'b1, 32'h40}
    };

    // Expected target k from the requirement formula (R5).
    function automatic logic [31:0] exp_tgt(input logic [31:0] a,
                                            input logic [31:0] s, input int k);
        logic [31:0] raw;
        raw = a + s * 32'(LA + k);
        return {raw[31:6], 6'b0};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one load for one cycle; leave the bench at the next negedge.
    task automatic do_load(input logic [15:0] pc, input logic [31:0] a);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_pc    = pc;
        ld_addr  = a;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // At a negedge: compare the head, then pop it across one edge.
    task automatic pop_expect(input logic [31:0] a, input string req);
        check(pf_valid === 1'b1, req, {31'b0, pf_valid}, 32'h1);
        check(pf_addr === a, req, pf_addr, a);
        pf_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pf_valid === 1'b0, "R1 idle in reset", {31'b0, pf_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid === 1'b0, "R1 idle after reset", {31'b0, pf_valid}, 32'h0);

        // Vector walk: every load checked for trigger and targets.
        for (int v = 0; v < NV; v++) begin
            do_load(VECS[v].pc, VECS[v].addr);
            if (VECS[v].trig) begin
                check(pf_valid === 1'b1, "R10 valid one cycle after load",
                      {31'b0, pf_valid}, 32'h1);
                for (int k = 0; k < DEG; k++)
                    pop_expect(exp_tgt(VECS[v].addr, VECS[v].stride, k), "R5 target");
                check(pf_valid === 1'b0, "R8 empty after drain", {31'b0, pf_valid}, 32'h0);
            end else begin
                check(pf_valid === 1'b0, "R3 R6 no trigger", {31'b0, pf_valid}, 32'h0);
            end
        end

        // Simultaneous push and pop, then a refused group (R9).
        do_load(16'h0084, 32'h4000);
        do_load(16'h0084, 32'h4100);
        do_load(16'h0084, 32'h4200);
        do_load(16'h0084, 32'h4300);          // queue: 4500 4600
        repeat (3) @(negedge clk);
        check(pf_addr === 32'h4500 && pf_valid, "R8 stall hold", pf_addr, 32'h4500);
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = 16'h0084; ld_addr = 32'h4400; pf_ready = 1'b1;
        @(posedge clk);                        // pop 4500, push 4600 4700
        @(negedge clk);
        pf_ready = 1'b0; ld_addr = 32'h4500;   // three held: one free, refused
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        pop_expect(32'h4600, "R8 R9 order after push+pop");
        pop_expect(32'h4600, "R9 new group k0");
        pop_expect(32'h4700, "R9 new group k1");
        check(pf_valid === 1'b0, "R9 full-group refused", {31'b0, pf_valid}, 32'h0);

        // Table still trained after the refusal (R9): next load triggers.
        do_load(16'h0084, 32'h4600);
        pop_expect(32'h4800, "R9 table updated on refusal");
        pop_expect(32'h4900, "R9 table updated on refusal");

        // Reset mid-run forgets training (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        do_load(16'h0084, 32'h4700);
        check(pf_valid === 1'b0, "R1 table cleared by reset", {31'b0, pf_valid}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule